// File: doc/BRIEF.md
# Read-Path Fault Injector

This block sits in the read-data return path of a memory and corrupts selected read words on purpose, so that downstream error detection and recovery logic can be exercised. Software programs up to four injection channels through a simple register bus. Each channel holds a word address to watch for and a 32-bit mask of data bits to invert. A channel is armed only when its own enable bit and a global enable bit are both set. Every read whose address matches an armed channel returns with the masked bits flipped, one cycle after it enters.

Injection does not stop after the first hit. It continues on every matching read until software clears the enable. Any write to a channel's descriptor disarms that channel. The channel enable bits are kept through a functional (system) reset and are cleared only by power-on reset.

Top module: `read_fault_injector`

## Requirements
- R1: After power-on reset (`porRstN` low), the control register, the channel-enable register and all descriptor words read as zero, and `outRdValid` is low.
- R2: The register map is as follows. Offset 0x00 is control, with the global enable at bit 0. Offset 0x04 holds the channel enables, with channel n at bit 31-n (channel 0 at bit 31, channel 3 at bit 28). Channel n's match address is at 0x10+8n and its inversion mask at 0x14+8n. Unused bits and unmapped offsets read as zero.
- R3: A channel corrupts a read only when its enable bit and the global enable bit are both set. If either is clear, the data passes through unchanged.
- R4: An armed channel matches a read when `memRdAddr[31:2]` equals its stored address bits [31:2]. The stored address always reads back with bits [1:0] zero. On a match the output is the read data XOR the channel mask.
- R5: When several armed channels match the same read, their masks are ORed before the XOR is applied.
- R6: An armed channel corrupts every matching read, repeatedly, until its enable is cleared.
- R7: A write to either descriptor word of channel n clears channel n's enable bit in that same clock edge and leaves the other channels' enables alone.
- R8: `outRdValid` and `outRdData` follow `memRdValid` and the (possibly corrupted) `memRdData` by exactly one clock, whether or not the read is corrupted.
- R9: A synchronous system reset (`sysRstN` low) clears the global enable and the output stage. It leaves the channel enables and the descriptors unchanged. Power-on reset clears them.
- R10: Clearing the global enable stops injection from the next read on and does not change any channel enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| sysRstN | input | 1 | System reset, synchronous, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memRdValid | input | 1 | Incoming read beat valid |
| memRdAddr | input | 32 | Address of the incoming read |
| memRdData | input | 32 | Data of the incoming read |
| outRdValid | output | 1 | Outgoing read beat valid |
| outRdData | output | 32 | Outgoing, possibly corrupted, read data |

## Verification
The properties assume that at most one register write arrives per cycle and that `regAddr` is stable while it is compared. They also assume that a system reset is never combined with a descriptor write when enable retention is checked, so the retention property excludes cycles in which `regWrEn` is high. The bench drives every input on the falling edge, issues one register access or one read at a time, and asserts `sysRstN` only while the register bus is idle. Each property's precondition is therefore met exactly as the bench intends.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int FI_NCH = 4;
  localparam int FI_DW  = 32;
  localparam int FI_AW  = 32;
  localparam int FI_RAW = 8;

  localparam logic [FI_RAW-1:0] FI_OFS_CTRL = 8'h00;
  localparam logic [FI_RAW-1:0] FI_OFS_CHEN = 8'h04;
  localparam int FI_OFS_DESC   = 16;
  localparam int FI_DESC_STEP  = 8;
  localparam int FI_MASK_SHIFT = 4;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic [FI_NCH-1:0] addrWr;
    logic [FI_NCH-1:0] maskWr;
    logic [FI_DW-1:0]  wrData;
    logic [FI_NCH-1:0] chArmed;
    logic              sysClr;
  } fiStrobe_t;
endpackage

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
#(
  parameter int NCH = FI_NCH,
  parameter int DW  = FI_DW,
  parameter int RAW = FI_RAW
) (
  input  logic            clk,
  input  logic            porRstN,
  input  logic            sysRstN,
  input  logic            regWrEn,
  input  logic [RAW-1:0]  regAddr,
  input  logic [DW-1:0]   regWrData,
  input  logic [DW-1:0]   descAddrRd [NCH],
  input  logic [DW-1:0]   descMaskRd [NCH],
  output logic [DW-1:0]   regRdData,
  output fiStrobe_t       strobe,
  output logic [NCH-1:0]  chEnVec,
  output logic            globalEn
);
  localparam int TOP_BIT = DW - 1;

  logic            ctrlHit;
  logic            chenHit;
  logic [NCH-1:0]  addrHit;
  logic [NCH-1:0]  maskHit;

  assign ctrlHit = (regAddr == FI_OFS_CTRL);
  assign chenHit = (regAddr == FI_OFS_CHEN);

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    localparam int ADDR_OFS = FI_OFS_DESC + n * FI_DESC_STEP;
    localparam int MASK_OFS = ADDR_OFS + FI_MASK_SHIFT;
    assign addrHit[n] = (regAddr == RAW'(ADDR_OFS));
    assign maskHit[n] = (regAddr == RAW'(MASK_OFS));

    // enables survive system reset; a descriptor write disarms the channel
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        chEnVec[n] <= 1'b0;
      end else if (regWrEn && (addrHit[n] || maskHit[n])) begin
        chEnVec[n] <= 1'b0;
      end else if (regWrEn && chenHit) begin
        chEnVec[n] <= regWrData[TOP_BIT - n];
      end
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      globalEn <= 1'b0;
    end else if (!sysRstN) begin
      globalEn <= 1'b0;
    end else if (regWrEn && ctrlHit) begin
      globalEn <= regWrData[0];
    end
  end

  always_comb begin
    strobe.addrWr  = addrHit & {NCH{regWrEn}};
    strobe.maskWr  = maskHit & {NCH{regWrEn}};
    strobe.wrData  = regWrData;
    strobe.chArmed = chEnVec & {NCH{globalEn}};
    strobe.sysClr  = ~sysRstN;
  end

  always_comb begin
    regRdData = '0;
    if (ctrlHit) begin
      regRdData[0] = globalEn;
    end
    if (chenHit) begin
      for (int n = 0; n < NCH; n++) begin
        regRdData[TOP_BIT - n] = chEnVec[n];
      end
    end
    for (int n = 0; n < NCH; n++) begin
      if (addrHit[n]) regRdData = descAddrRd[n];
      if (maskHit[n]) regRdData = descMaskRd[n];
    end
  end
endmodule

// File: rtl/fi_datapath.sv
module fi_datapath
  import fi_pkg::*;
#(
  parameter int NCH = FI_NCH,
  parameter int DW  = FI_DW,
  parameter int AW  = FI_AW
) (
  input  logic           clk,
  input  logic           porRstN,
  input  fiStrobe_t      strobe,
  input  logic           memRdValid,
  input  logic [AW-1:0]  memRdAddr,
  input  logic [DW-1:0]  memRdData,
  output logic           outRdValid,
  output logic [DW-1:0]  outRdData,
  output logic [DW-1:0]  descAddrRd [NCH],
  output logic [DW-1:0]  descMaskRd [NCH]
);
  localparam int WORD_LSB = 2;

  logic [AW-1:WORD_LSB] descAddr [NCH];
  logic [DW-1:0]        descMask [NCH];
  logic [NCH-1:0]       hitVec;
  logic [DW-1:0]        flipMask;

  for (genvar n = 0; n < NCH; n++) begin : g_desc
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        descAddr[n] <= '0;
      end else if (strobe.addrWr[n]) begin
        descAddr[n] <= strobe.wrData[AW-1:WORD_LSB];
      end
    end

    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        descMask[n] <= '0;
      end else if (strobe.maskWr[n]) begin
        descMask[n] <= strobe.wrData;
      end
    end

    assign descAddrRd[n] = DW'({descAddr[n], {WORD_LSB{1'b0}}});
    assign descMaskRd[n] = descMask[n];
    assign hitVec[n] = strobe.chArmed[n] && (memRdAddr[AW-1:WORD_LSB] == descAddr[n]);
  end

  always_comb begin
    flipMask = '0;
    for (int n = 0; n < NCH; n++) begin
      if (hitVec[n]) flipMask = flipMask | descMask[n];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      outRdValid <= 1'b0;
      outRdData  <= '0;
    end else if (strobe.sysClr) begin
      outRdValid <= 1'b0;
      outRdData  <= '0;
    end else begin
      outRdValid <= memRdValid;
      outRdData  <= memRdData ^ flipMask;
    end
  end
endmodule

// File: rtl/read_fault_injector.sv
module read_fault_injector
  import fi_pkg::*;
#(
  parameter int NCH = FI_NCH,
  parameter int DW  = FI_DW,
  parameter int AW  = FI_AW,
  parameter int RAW = FI_RAW
) (
  input  logic           clk,
  input  logic           porRstN,
  input  logic           sysRstN,
  input  logic           regWrEn,
  input  logic [RAW-1:0] regAddr,
  input  logic [DW-1:0]  regWrData,
  output logic [DW-1:0]  regRdData,
  input  logic           memRdValid,
  input  logic [AW-1:0]  memRdAddr,
  input  logic [DW-1:0]  memRdData,
  output logic           outRdValid,
  output logic [DW-1:0]  outRdData
);
  fiStrobe_t       strobe;
  logic [NCH-1:0]  chEnVec;
  logic            globalEn;
  logic [DW-1:0]   descAddrRd [NCH];
  logic [DW-1:0]   descMaskRd [NCH];

  fi_ctrl #(.NCH(NCH), .DW(DW), .RAW(RAW)) u_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .sysRstN    (sysRstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .descAddrRd (descAddrRd),
    .descMaskRd (descMaskRd),
    .regRdData  (regRdData),
    .strobe     (strobe),
    .chEnVec    (chEnVec),
    .globalEn   (globalEn)
  );

  fi_datapath #(.NCH(NCH), .DW(DW), .AW(AW)) u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .strobe     (strobe),
    .memRdValid (memRdValid),
    .memRdAddr  (memRdAddr),
    .memRdData  (memRdData),
    .outRdValid (outRdValid),
    .outRdData  (outRdData),
    .descAddrRd (descAddrRd),
    .descMaskRd (descMaskRd)
  );
endmodule

// File: rtl/read_fault_injector_chk.sv
module read_fault_injector_chk
  import fi_pkg::*;
#(
  parameter int NCH = FI_NCH,
  parameter int DW  = FI_DW,
  parameter int AW  = FI_AW,
  parameter int RAW = FI_RAW
) (
  input logic           clk,
  input logic           porRstN,
  input logic           sysRstN,
  input logic           regWrEn,
  input logic [RAW-1:0] regAddr,
  input logic [DW-1:0]  regRdData,
  input logic           memRdValid,
  input logic [DW-1:0]  memRdData,
  input logic           outRdValid,
  input logic [DW-1:0]  outRdData,
  input logic [NCH-1:0] chEnVec,
  input logic           globalEn
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!porRstN)
    sysRstN |=> (outRdValid == $past(memRdValid)));

  a_r9_sysrst_clears_out: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> !outRdValid);

  a_r9_sysrst_keeps_en: assert property (@(posedge clk) disable iff (!porRstN)
    (!sysRstN && !regWrEn) |=> (chEnVec == $past(chEnVec)));

  a_r3_no_global_passes: assert property (@(posedge clk) disable iff (!porRstN)
    (sysRstN && !globalEn) |=> (outRdData == $past(memRdData)));

  a_r2_chen_low_zero: assert property (@(posedge clk) disable iff (!porRstN)
    (regAddr == FI_OFS_CHEN) |-> (regRdData[DW-NCH-1:0] == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    localparam int ADDR_OFS = FI_OFS_DESC + n * FI_DESC_STEP;
    a_r7_desc_clears_en: assert property (@(posedge clk) disable iff (!porRstN)
      (regWrEn && (regAddr == RAW'(ADDR_OFS) || regAddr == RAW'(ADDR_OFS + FI_MASK_SHIFT)))
      |=> !chEnVec[n]);
  end
endmodule

bind read_fault_injector read_fault_injector_chk #(.NCH(NCH), .DW(DW), .AW(AW), .RAW(RAW)) u_chk (
  .clk        (clk),
  .porRstN    (porRstN),
  .sysRstN    (sysRstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regRdData  (regRdData),
  .memRdValid (memRdValid),
  .memRdData  (memRdData),
  .outRdValid (outRdValid),
  .outRdData  (outRdData),
  .chEnVec    (chEnVec),
  .globalEn   (globalEn)
);

// File: tb/read_fault_injector_bench.sv
module read_fault_injector_bench;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdAddr = '0;
  logic [31:0] memRdData = '0;
  logic        outRdValid;
  logic [31:0] outRdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  read_fault_injector u_read_fault_injector (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdValid(memRdValid), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .outRdValid(outRdValid), .outRdData(outRdData)
  );

  // address, input data, expected output with all channels armed
  localparam logic [95:0] VEC [7] = '{
    {32'h0000_0100, 32'h1234_5678, 32'h1234_A987},
    {32'h0000_0200, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {32'h0000_0300, 32'h0000_0000, 32'h0000_0001},
    {32'h0000_0400, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {32'h0000_0102, 32'h0000_0000, 32'h0000_FFFF},
    {32'h0000_0104, 32'hAAAA_5555, 32'hAAAA_5555},
    {32'h0000_0100, 32'h0000_0000, 32'h0000_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic memRead(input logic [31:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    memRdValid = 1'b1; memRdAddr = a; memRdData = d;
    @(negedge clk);
    memRdValid = 1'b0;
    q = outRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;

    // R1 reset state
    regRead(8'h00, rd); check("R1 ctrl", rd, 32'h0);
    regRead(8'h04, rd); check("R1 chen", rd, 32'h0);
    regRead(8'h10, rd); check("R1 desc0 addr", rd, 32'h0);
    regRead(8'h2C, rd); check("R1 desc3 mask", rd, 32'h0);
    check("R1 valid", {31'd0, outRdValid}, 32'h0);

    // program descriptors
    regWrite(8'h10, 32'h0000_0100); regWrite(8'h14, 32'h0000_00FF);
    regWrite(8'h18, 32'h0000_0200); regWrite(8'h1C, 32'hF000_0000);
    regWrite(8'h20, 32'h0000_0100); regWrite(8'h24, 32'h0000_FF00);
    regWrite(8'h28, 32'h0000_0300); regWrite(8'h2C, 32'h0000_0001);
    regWrite(8'h04, 32'hFFFF_FFFF);
    regRead(8'h04, rd); check("R2 chen bits", rd, 32'hF000_0000);
    regWrite(8'h00, 32'hFFFF_FFFF);
    regRead(8'h00, rd); check("R2 ctrl bits", rd, 32'h0000_0001);
    regRead(8'h40, rd); check("R2 unmapped", rd, 32'h0);

    // table: R4 match and XOR, R5 OR of masks, R6 repeated hits
    for (int i = 0; i < 7; i++) begin
      memRead(VEC[i][95:64], VEC[i][63:32], rd);
      check("R4/R5/R6 vector", rd, VEC[i][31:0]);
      check("R8 valid", {31'd0, outRdValid}, 32'h1);
    end
    @(negedge clk);
    check("R8 valid drop", {31'd0, outRdValid}, 32'h0);

    // R2 bit order: channel 0 at bit 31, channel 2 at bit 29
    regWrite(8'h04, 32'h8000_0000);
    memRead(32'h100, 32'h0, rd); check("R2 ch0 only", rd, 32'h0000_00FF);
    regWrite(8'h04, 32'h2000_0000);
    memRead(32'h100, 32'h0, rd); check("R2 ch2 only", rd, 32'h0000_FF00);

    // R3 both enables needed
    regWrite(8'h00, 32'h0); regWrite(8'h04, 32'hF000_0000);
    memRead(32'h100, 32'h0, rd); check("R3 no global", rd, 32'h0);
    regWrite(8'h00, 32'h1); regWrite(8'h04, 32'h0);
    memRead(32'h100, 32'h0, rd); check("R3 no channel", rd, 32'h0);

    // R10 global off stops injection, keeps channel bits
    regWrite(8'h04, 32'hF000_0000);
    memRead(32'h100, 32'h0, rd); check("R10 armed", rd, 32'h0000_FFFF);
    regWrite(8'h00, 32'h0);
    memRead(32'h100, 32'h0, rd); check("R10 stopped", rd, 32'h0);
    regRead(8'h04, rd); check("R10 chen kept", rd, 32'hF000_0000);

    // R7 descriptor writes disarm only their channel
    regWrite(8'h18, 32'h0000_0203);
    regRead(8'h04, rd); check("R7 addr write ch1", rd, 32'hB000_0000);
    regRead(8'h18, rd); check("R4 addr low bits", rd, 32'h0000_0200);
    regWrite(8'h2C, 32'h0000_0001);
    regRead(8'h04, rd); check("R7 mask write ch3", rd, 32'hA000_0000);

    // R9 system reset keeps enables and descriptors
    regWrite(8'h00, 32'h1);
    @(negedge clk); sysRstN = 1'b0;
    @(negedge clk); @(negedge clk); sysRstN = 1'b1;
    regRead(8'h04, rd); check("R9 chen kept", rd, 32'hA000_0000);
    regRead(8'h00, rd); check("R9 global cleared", rd, 32'h0);
    regRead(8'h14, rd); check("R9 desc kept", rd, 32'h0000_00FF);
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    regRead(8'h04, rd); check("R9 por clears chen", rd, 32'h0);
    regRead(8'h14, rd); check("R9 por clears desc", rd, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule